// File: doc/BRIEF.md
# Selectable Square-Wave Rate Output

This block turns a 32768 Hz reference tick into a square wave on an open-drain style output. A 4-bit rate select picks one of fifteen rates, from 32768 Hz down to one cycle every 32 seconds. An all-zero select switches the function off. The wave comes from one binary counter that advances on each reference tick. Every rate taps one bit of that counter, so all rates share one time base.

The output pin is modelled as a pull-low enable. When `pull_low` is 1 the pin drives low. When it is 0 the pin is released and an external pull-up sets the level. The pin is never driven high. A control bit can switch the output off while the system runs from its backup battery. With that bit clear, the wave continues on battery. A flag, `fmode_active`, tells other logic when the rate select is nonzero.

A change of select is taken at the next clock edge. That edge also clears the counter, so every new rate begins with a full released half period.

Top module: `freq_tap_out`

## Requirements
- R1: With select 0000 the output is released (`pull_low` = 0) at every tick pattern and battery state.
- R2: With select 0001 the output follows the reference tick at 32768 Hz. `pull_low` is 0 in each cycle where `tick_32k` is 1 and 1 in every other cycle.
- R3: Select 0010 gives a half period of 4 ticks (4096 Hz) and select 0011 gives a half period of 16 ticks (1024 Hz). Each period is released for its first half and pulled low for its second half.
- R4: Selects 0100 through 1111 give half periods of 256·2^(select−4) ticks, which is 64, 32, 16, 8, 4, 2, 1, 1/2, 1/4, 1/8, 1/16 and 1/32 Hz. Each period is released for its first half and pulled low for its second half.
- R5: A new select value is taken at the clock edge after it appears. That edge restarts the phase, so the first half period of the new rate is a full released half. A tick on that edge is not counted. A select that stays the same never restarts the phase.
- R6: While `bat_gate_off` = 1 and `on_battery` = 1, the output is released. The counter keeps counting ticks during this time, so the wave resumes in phase when the gating ends.
- R7: While `bat_gate_off` = 0, the output runs on battery the same as on mains power.
- R8: `pull_low` is the only pin control. It is asserted only while the taken select is nonzero and battery gating is not in force.
- R9: `fmode_active` is 1 in exactly the cycles where `rate_sel` is nonzero, with no clock delay.
- R10: During reset the output is released and the counter is cleared, whatever the select is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the reference tick |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| rate_sel | input | 4 | Rate select. 0000 is off; other codes are given in R2–R4 |
| bat_gate_off | input | 1 | 1 = switch the output off while on battery |
| on_battery | input | 1 | 1 = backup battery is the active supply |
| pull_low | output | 1 | 1 = drive the pin low, 0 = release it |
| fmode_active | output | 1 | Rate select is nonzero |

## Verification
Two functions can act on the same clock edge: a change of select, which restarts the phase, and a reference tick, which would advance the counter. The driver asserts the tick on every edge where it applies a new select. The scoreboard then expects the full first released half period to start from zero, which shows that the restart won and the tick was dropped. Battery gating is also turned on and off in the middle of a period at an unchanged select. The expected values carry the same tick count across the gated stretch, so a counter that froze or restarted while gated would show up as a phase error once gating ends.

// File: rtl/freq_tap_out.sv
module freq_tap_out #(
  parameter int CNT_W = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic [3:0] rate_sel,
  input  logic       bat_gate_off,
  input  logic       on_battery,
  output logic       pull_low,
  output logic       fmode_active
);

  localparam int IW = $clog2(CNT_W);

  logic [3:0]       sel_q;
  logic [CNT_W-1:0] cnt;
  logic [IW-1:0]    tap_idx;
  logic             level;
  logic             gated;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt   <= '0;
    end else if (rate_sel != sel_q) begin
      sel_q <= rate_sel;
      cnt   <= '0;
    end else if (tick_32k) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tap_idx = IW'(sel_q) + IW'(4);

  always_comb begin
    case (sel_q)
      4'd0:    level = 1'b0;
      4'd1:    level = ~tick_32k;
      4'd2:    level = cnt[2];
      4'd3:    level = cnt[4];
      default: level = cnt[tap_idx];
    endcase
  end

  assign gated        = bat_gate_off & on_battery;
  assign pull_low     = level & ~gated;
  assign fmode_active = |rate_sel;

endmodule

// File: rtl/freq_tap_out_chk.sv
module freq_tap_out_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_32k,
  input logic [3:0]       rate_sel,
  input logic             bat_gate_off,
  input logic             on_battery,
  input logic             pull_low,
  input logic [3:0]       sel_q,
  input logic [CNT_W-1:0] cnt
);

  p_off_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> !pull_low);

  p_tick_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 4'd1 && !tick_32k && !(bat_gate_off && on_battery)) |-> pull_low);

  p_tick_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == sel_q && tick_32k) |=> (cnt == $past(cnt) + 1'b1));

  p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == sel_q && !tick_32k) |=> $stable(cnt));

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != sel_q) |=> (cnt == '0 && sel_q == $past(rate_sel)));

  p_first_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q >= 4'd2 && cnt == '0) |-> !pull_low);

  p_bat_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_gate_off && on_battery) |-> !pull_low);

  p_pull_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> (sel_q != 4'd0));

endmodule

bind freq_tap_out freq_tap_out_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_32k     (tick_32k),
  .rate_sel     (rate_sel),
  .bat_gate_off (bat_gate_off),
  .on_battery   (on_battery),
  .pull_low     (pull_low),
  .sel_q        (sel_q),
  .cnt          (cnt)
);

// File: tb/freq_tap_out_tb.sv
`timescale 1ns/1ps
module freq_tap_out_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       bat_gate_off = 1'b0;
  logic       on_battery = 1'b0;
  logic       pull_low;
  logic       fmode_active;

  always #2.5 clk = ~clk;

  freq_tap_out u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_32k     (tick_32k),
    .rate_sel     (rate_sel),
    .bat_gate_off (bat_gate_off),
    .on_battery   (on_battery),
    .pull_low     (pull_low),
    .fmode_active (fmode_active)
  );

  typedef struct {
    logic  low;
    logic  fm;
    string tag;
  } exp_t;

  exp_t   q[$];
  exp_t   mon_e;
  int     checks = 0;
  int     failures = 0;
  bit     done = 0;
  logic [3:0] cur_sel = 4'd0;
  longint m = 0;

  function automatic logic exp_low(input logic [3:0] s, input longint ticks,
                                   input logic t, input logic gated);
    longint h;
    if (gated || s == 4'd0) return 1'b0;
    if (s == 4'd1) return !t;
    if (s == 4'd2) h = 4;
    else if (s == 4'd3) h = 16;
    else h = longint'(256) << (s - 4);
    return ((ticks / h) % 2) == 1;
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      checks += 2;
      if (pull_low !== mon_e.low) begin
        failures++;
        $display("FAIL %s pull_low actual=%b expected=%b sel=%0d t=%0t",
                 mon_e.tag, pull_low, mon_e.low, rate_sel, $time);
      end
      if (fmode_active !== mon_e.fm) begin
        failures++;
        $display("FAIL %s/R9 fmode_active actual=%b expected=%b t=%0t",
                 mon_e.tag, fmode_active, mon_e.fm, $time);
      end
    end
  end

  task automatic run(input logic [3:0] s, input int n, input int tmode,
                     input logic g, input logic b, input string tag);
    exp_t e;
    if (s != cur_sel) begin
      rate_sel = s;
      tick_32k = 1'b1;
      @(posedge clk); #1;
      m = 0;
      cur_sel = s;
    end
    for (int i = 0; i < n; i++) begin
      bat_gate_off = g;
      on_battery   = b;
      tick_32k = (tmode == 0) ? 1'b1 : (tmode == 1) ? (i % 2 == 0) : (i % 3 == 0);
      e.low = exp_low(s, m, tick_32k, g && b);
      e.fm  = (s != 4'd0);
      e.tag = tag;
      q.push_back(e);
      @(posedge clk); #1;
      if (tick_32k) m++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rate_sel = 4'd3;
    tick_32k = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks += 2;
    if (pull_low !== 1'b0) begin
      failures++;
      $display("FAIL R10 reset pull_low actual=%b expected=0", pull_low);
    end
    if (fmode_active !== 1'b1) begin
      failures++;
      $display("FAIL R10/R9 reset fmode_active actual=%b expected=1", fmode_active);
    end
    rate_sel = 4'd0;
    tick_32k = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    cur_sel = 4'd0;
    m = 0;

    run(4'd0, 50, 1, 1'b0, 1'b1, "R1");
    run(4'd0, 20, 0, 1'b1, 1'b0, "R1");
    run(4'd1, 40, 1, 1'b0, 1'b0, "R2");
    run(4'd1, 30, 2, 1'b0, 1'b1, "R2");
    run(4'd2, 40, 0, 1'b0, 1'b0, "R3");
    run(4'd2, 60, 2, 1'b0, 1'b0, "R3");
    run(4'd3, 70, 0, 1'b0, 1'b0, "R3");
    run(4'd3, 21, 0, 1'b0, 1'b0, "R5");
    run(4'd2, 6, 0, 1'b0, 1'b0, "R5");
    run(4'd2, 30, 1, 1'b0, 1'b0, "R5");
    run(4'd3, 40, 0, 1'b0, 1'b0, "R5");

    for (int s = 4; s <= 11; s++) begin
      run(4'(s), (512 << (s - 4)) + 8, 0, 1'b0, 1'b0, "R4");
    end
    run(4'd12, 33000, 0, 1'b0, 1'b0, "R4");
    for (int s = 13; s <= 15; s++) begin
      run(4'(s), 1500, 0, 1'b0, 1'b0, "R4");
    end

    run(4'd4, 300, 0, 1'b0, 1'b1, "R7");
    run(4'd4, 400, 0, 1'b1, 1'b1, "R6/R8");
    run(4'd4, 300, 0, 1'b1, 1'b0, "R7");
    run(4'd4, 200, 1, 1'b0, 1'b1, "R7");
    run(4'd1, 20, 1, 1'b1, 1'b1, "R6");
    run(4'd0, 20, 1, 1'b0, 1'b0, "R1");

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule